// File: doc/BRIEF.md
# Alarm Interrupt and Clock-Select Pin Controller

This block sits behind two alarm comparators in a real-time clock. Each comparator raises a one-cycle match strobe. The block keeps one sticky status flag per alarm. It also drives a single shared output pin. In alarm mode, that pin is an active-low interrupt that gives one fixed-width pulse per qualifying event. The pin can instead carry a divided copy of the 32.768 kHz oscillator clock that runs the block.

The flags record every match, whether or not its interrupt is enabled. They stay set until the status register is read. A one-cycle read-done strobe marks the end of that read. A mode bit selects how the pulse behaves. In one-shot mode, only one pulse is produced until the next status read. In recurring mode, every enabled match that occurs outside a pulse produces a new pulse. A two-bit select field hands the pin over to a clock output, and while that field is not zero the interrupt function is off.

Top module: `alarm_irq_fout`

## Requirements
- R1: After reset, `flag0` and `flag1` are 0 and `irq_n` is 1 when `fsel` is 00.
- R2: A match strobe on alarm k sets `flagk` on the next clock edge, regardless of `enk`, `fsel` and the mode bit. A match on a disabled alarm produces no pulse.
- R3: A `stat_rd` strobe with no match in the same cycle clears both flags on the next edge. It also re-arms the one-shot pulse.
- R4: With `fsel` = 00, an enabled match that qualifies drives `irq_n` low from the next edge for exactly PULSE_CYCLES cycles (512 by default), after which it returns high.
- R5: With `repeat_mode` = 0, no further pulse appears after a pulse until a `stat_rd` strobe. With `repeat_mode` = 1, every enabled match that arrives outside a pulse starts a new pulse.
- R6: A match that arrives during an active pulse leaves the pulse's end cycle unchanged, and it still sets its flag.
- R7: A match and a `stat_rd` strobe in the same cycle leave that alarm's flag set.
- R8: `fsel` picks the pin source. 00 selects the interrupt. 01 makes `irq_n` equal `clk`. 10 makes it bit 2 of n. 11 makes it bit 14 of n. Here n is the number of clock edges since reset was released (4096 Hz and 1 Hz).
- R9: While `fsel` is not 00, no pulse starts and any running pulse is dropped, so `irq_n` is high on return to 00. Flags keep updating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| match0 | input | 1 | Alarm 0 match strobe |
| match1 | input | 1 | Alarm 1 match strobe |
| en0 | input | 1 | Alarm 0 interrupt enable |
| en1 | input | 1 | Alarm 1 interrupt enable |
| repeat_mode | input | 1 | 1 = recurring pulses, 0 = one-shot |
| fsel | input | 2 | Pin source select |
| stat_rd | input | 1 | Status-read done strobe |
| flag0 | output | 1 | Alarm 0 sticky status |
| flag1 | output | 1 | Alarm 1 sticky status |
| irq_n | output | 1 | Shared pin: interrupt (low active) or clock |

## Verification
Flags and the pulse start are due one edge after the strobe, and the pulse release is due PULSE_CYCLES + 1 edges after it. A clock source chosen by `fsel` appears on the pin in the same cycle, and the divided levels follow the count of edges since reset. The driver stamps each expectation with the absolute cycle number at which the result is due. The monitor samples 1 ns after every falling edge and compares only the items due at that cycle. The full-rate clock output is checked directly on both clock phases.

// File: rtl/alarm_irq_fout.sv
module alarm_irq_fout #(
  parameter int PULSE_CYCLES = 512,
  parameter int FAST_DIV     = 8,
  parameter int SLOW_DIV     = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       match0,
  input  logic       match1,
  input  logic       en0,
  input  logic       en1,
  input  logic       repeat_mode,
  input  logic [1:0] fsel,
  input  logic       stat_rd,
  output logic       flag0,
  output logic       flag1,
  output logic       irq_n
);
  localparam int PW = $clog2(PULSE_CYCLES);
  localparam int DW = $clog2(SLOW_DIV);
  localparam int FB = $clog2(FAST_DIV) - 1;

  logic [PW-1:0] cnt;
  logic [DW-1:0] div_cnt;
  logic          active, armed;

  wire alarm_sel = (fsel == 2'b00);
  wire hit       = (match0 & en0) | (match1 & en1);
  wire fire      = alarm_sel & hit & ~active & (repeat_mode | armed);
  wire last      = (cnt == PW'(PULSE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag0 <= 1'b0;
      flag1 <= 1'b0;
    end else begin
      flag0 <= match0 | (flag0 & ~stat_rd);
      flag1 <= match1 | (flag1 & ~stat_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      armed  <= 1'b1;
    end else begin
      if (!alarm_sel) begin
        active <= 1'b0;
      end else if (fire) begin
        active <= 1'b1;
        cnt    <= '0;
      end else if (active) begin
        if (last) active <= 1'b0;
        cnt <= cnt + 1'b1;
      end
      if (fire && !repeat_mode) armed <= 1'b0;
      else if (stat_rd)         armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) div_cnt <= '0;
    else        div_cnt <= div_cnt + 1'b1;
  end

  always_comb begin
    case (fsel)
      2'b00:   irq_n = ~active;
      2'b01:   irq_n = clk;
      2'b10:   irq_n = div_cnt[FB];
      default: irq_n = div_cnt[DW-1];
    endcase
  end

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match0 |=> flag0);

  // R3
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !match1) |=> !flag1);

  // R4
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(hit));

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && alarm_sel && !last) |=> (active && cnt == $past(cnt) + 1'b1));

  // R9
  clk_mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_sel |=> !active);
endmodule

// File: tb/sim_alarm_irq_fout.sv
module sim_alarm_irq_fout;
  logic clk = 1'b0, rst_n = 1'b0;
  logic match0 = 0, match1 = 0, en0 = 0, en1 = 0, repeat_mode = 0, stat_rd = 0;
  logic [1:0] fsel = 2'b00;
  logic flag0, flag1, irq_n;

  alarm_irq_fout u0 (.clk(clk), .rst_n(rst_n), .match0(match0), .match1(match1),
    .en0(en0), .en1(en1), .repeat_mode(repeat_mode), .fsel(fsel), .stat_rd(stat_rd),
    .flag0(flag0), .flag1(flag1), .irq_n(irq_n));

  always #5 clk = ~clk;

  typedef struct { int cyc; int field; logic val; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic push(input int c, input int f, input logic v, input string r);
    exp_t e;
    e.cyc = c; e.field = f; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  // monitor: field 0 = pin, 1 = flag0, 2 = flag1
  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      logic act;
      e = q.pop_front();
      act = (e.field == 0) ? irq_n : (e.field == 1) ? flag0 : flag1;
      checks++;
      if (e.cyc != cyc || act !== e.val) begin
        errors++;
        $display("FAIL %s cyc=%0d field=%0d actual=%b expected=%b", e.req, cyc, e.field, act, e.val);
      end
    end
  end

  task automatic go(input logic m0, input logic m1, input logic rd, output int n);
    @(negedge clk);
    n = cyc;
    match0 = m0; match1 = m1; stat_rd = rd;
    @(negedge clk);
    match0 = 0; match1 = 0; stat_rd = 0;
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic direct(input logic act, input logic exp, input string r);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", r, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, m, k, t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n = cyc;
    push(n + 1, 0, 1, "R1"); push(n + 1, 1, 0, "R1"); push(n + 1, 2, 0, "R1");
    drain();

    en0 = 1;
    go(1, 0, 0, n);
    push(n + 1, 1, 1, "R2"); push(n + 1, 0, 0, "R4");
    push(n + 512, 0, 0, "R4"); push(n + 513, 0, 1, "R4");
    drain();

    go(1, 0, 0, n);
    push(n + 1, 0, 1, "R5"); push(n + 300, 0, 1, "R5");
    drain();

    go(0, 0, 1, n);
    push(n + 1, 1, 0, "R3");
    drain();
    go(1, 0, 0, n);
    push(n + 1, 0, 0, "R3"); push(n + 513, 0, 1, "R4");
    drain();
    go(0, 0, 1, n);
    drain();

    en1 = 0;
    go(0, 1, 0, n);
    push(n + 1, 2, 1, "R2"); push(n + 1, 0, 1, "R2"); push(n + 4, 0, 1, "R2");
    drain();
    go(0, 0, 1, n);
    push(n + 1, 2, 0, "R3");
    drain();

    go(1, 0, 1, n);
    push(n + 1, 1, 1, "R7"); push(n + 513, 0, 1, "R7");
    drain();
    go(0, 0, 1, n);
    drain();

    en1 = 1;
    go(1, 0, 0, n);
    push(n + 1, 0, 0, "R6");
    repeat (98) @(negedge clk);
    go(0, 1, 0, m);
    push(m + 1, 2, 1, "R6"); push(m + 1, 0, 0, "R6");
    push(n + 512, 0, 0, "R6"); push(n + 513, 0, 1, "R6");
    drain();
    go(0, 0, 1, n);
    drain();

    repeat_mode = 1;
    go(0, 1, 0, n);
    push(n + 1, 0, 0, "R5"); push(n + 513, 0, 1, "R5");
    drain();
    go(0, 1, 0, n);
    push(n + 1, 0, 0, "R5"); push(n + 513, 0, 1, "R5");
    drain();
    repeat_mode = 0;
    go(0, 0, 1, n);
    drain();

    go(1, 0, 0, n);
    repeat (10) @(negedge clk);
    fsel = 2'b10;
    k = cyc;
    for (int c = k + 1; c <= k + 20; c++) push(c, 0, logic'((c >> 2) & 1), "R8");
    drain();
    go(0, 0, 1, n);
    go(1, 0, 0, m);
    push(m + 1, 1, 1, "R9");
    for (int c = m + 1; c <= m + 20; c++) push(c, 0, logic'((c >> 2) & 1), "R9");
    drain();
    fsel = 2'b00;
    n = cyc;
    push(n + 1, 0, 1, "R9"); push(n + 3, 0, 1, "R9");
    drain();

    fsel = 2'b11;
    t = ((cyc >> 14) + 1) << 14;
    for (int c = t - 2; c <= t + 1; c++) push(c, 0, logic'((c >> 14) & 1), "R8");
    drain();

    fsel = 2'b01;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1 direct(irq_n, 1'b1, "R8");
      @(negedge clk); #1 direct(irq_n, 1'b0, "R8");
    end
    fsel = 2'b00;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule